// File: doc/BRIEF.md
# UART Interrupt Prioritizer with Modem Status

This block gathers the interrupt sources of one serial channel, ranks them and reports the winner to the processor as a small identification code. It also owns the modem side of the channel. It synchronizes the four active-low modem inputs, records each change of those inputs as a sticky delta bit, and drives the modem control pins from a control register. A loopback mode turns the control bits back into status bits, so that software can test the channel without a modem attached.

The line-status and receive-data conditions come from neighbouring logic, which clears them when the processor reads the matching registers. This block keeps the transmit-empty condition itself, as a latched flag. It decodes register reads and writes from a simple strobe-and-address bus. The interrupt line is the OR of all enabled pending sources, gated by the OUT2 control bit.

Top module: `uart_irq_modem`

## Requirements
- R1: A write with address 1 while `dlab_i` is low loads the interrupt enable register from data bits 3..0. Bit 0 enables received data, bit 1 enables transmit-empty, bit 2 enables line status and bit 3 enables modem status. `ier_o` bits 7..4 always read 0.
- R2: `iir_o[3:0]` encodes the highest enabled pending source, ranked from line status (0110) through received data (0100) and transmit-empty (0010) down to modem status (0000). It reads 0001 when no enabled source is pending, and bits 7..4 always read 0.
- R3: The line-status source is pending while `line_err_i` is high, and the received-data source is pending while `rx_ready_i` is high. Both follow these inputs in the same cycle.
- R4: The transmit-empty flag sets when `thre_i` rises, or when an IER write turns bit 1 on while `thre_i` is high. It clears on a write to address 0 while `dlab_i` is low. It also clears on a read of address 2 that returns code 0010.
- R5: Bits 0, 1 and 3 of `msr_o` set when the CTS, DSR or carrier status changes. Bit 2 sets when the ring pin goes from low to high. A read of address 6 clears all four bits, but a change that lands in the same cycle as the read stays set.
- R6: `msr_o` bits 4, 5, 6 and 7 are the inverted CTS, DSR, ring and carrier pins. A pin change becomes visible after the third rising clock edge.
- R7: A write to address 4 loads MCR bits 4..0, and `mcr_o` bits 7..5 read 0. Outside loopback, `dtr_n_o`, `rts_n_o`, `out1_n_o` and `out2_n_o` are the inverses of MCR bits 0, 1, 2 and 3.
- R8: While MCR bit 4 is set, all four control pins are high and the modem pins are ignored. In this mode CTS shows MCR bit 1, DSR shows bit 0, ring shows bit 2 and carrier shows bit 3, and the delta bits track these.
- R9: `irq_o` is high exactly when MCR bit 3 is set and `iir_o[0]` is 0.
- R10: Reset clears IER, MCR and `msr_o[3:0]` and drives all four control pins high. After reset `iir_o` reads 0x01 and `irq_o` is low.
- R11: While `dlab_i` is high, writes to addresses 0 and 1 change neither IER nor the transmit-empty flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_rd | input | 1 | Register read strobe, one cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| dlab_i | input | 1 | Divisor access bit from the line control register |
| line_err_i | input | 1 | Any receive error flag is set |
| rx_ready_i | input | 1 | Received character waiting |
| thre_i | input | 1 | Transmit holding register empty |
| cts_n_i | input | 1 | Clear-to-send pin, active low |
| dsr_n_i | input | 1 | Data-set-ready pin, active low |
| ri_n_i | input | 1 | Ring pin, active low |
| dcd_n_i | input | 1 | Carrier-detect pin, active low |
| ier_o | output | 8 | Interrupt enable register value |
| iir_o | output | 8 | Interrupt identification value |
| mcr_o | output | 8 | Modem control register value |
| msr_o | output | 8 | Modem status register value |
| dtr_n_o | output | 1 | Terminal-ready pin, active low |
| rts_n_o | output | 1 | Request-to-send pin, active low |
| out1_n_o | output | 1 | General output 1, active low |
| out2_n_o | output | 1 | General output 2, active low |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions take three things for granted about the inputs. Read and write strobes never rise in the same cycle. The neighbouring logic holds `line_err_i` until the status read it owns. A modem pin holds its level long enough to pass the synchronizer. The bench drives every input at the falling edge, issues one register access at a time, and keeps each pin level for several cycles. The single exception is the case where a pin change is deliberately timed to meet an MSR read.

// File: rtl/uirq_pkg.sv
// Shared constants and types for the interrupt/modem block.
// Assumes a 3-bit register address and an 8-bit data bus.
package uirq_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int IER_W  = 4;
    localparam int MCR_W  = 5;
    localparam int NMODEM = 4;

    localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] A_IER  = 3'd1;
    localparam logic [ADDR_W-1:0] A_IIR  = 3'd2;
    localparam logic [ADDR_W-1:0] A_MCR  = 3'd4;
    localparam logic [ADDR_W-1:0] A_MSR  = 3'd6;

    typedef enum logic [3:0] {
        IID_NONE  = 4'b0001,
        IID_LINE  = 4'b0110,
        IID_RXD   = 4'b0100,
        IID_THRE  = 4'b0010,
        IID_MODEM = 4'b0000
    } iid_t;
endpackage

// File: rtl/uirq_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pins.
// Assumes active-low pins, so every stage resets to 1 (inactive). STAGES >= 2.
module uirq_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        // Shift the pin level through the stage chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], d[i]};
        end
        assign q[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/uirq_regs.sv
// Register decode and storage for the interrupt enable and modem control registers.
// Assumes single-cycle strobes, with read and write never asserted together.
module uirq_regs
    import uirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              dlab,
    input  logic              thre,
    output logic [IER_W-1:0]  ier,
    output logic [MCR_W-1:0]  mcr,
    output logic              thr_wr,
    output logic              thre_arm,
    output logic              rd_iir,
    output logic              rd_msr
);
    logic wr_ier, wr_mcr;
    logic unused_wbits;

    // Decode the strobes for each register.
    always_comb begin
        wr_ier   = bus_wr && bus_addr == A_IER  && !dlab;
        thr_wr   = bus_wr && bus_addr == A_DATA && !dlab;
        wr_mcr   = bus_wr && bus_addr == A_MCR;
        rd_iir   = bus_rd && bus_addr == A_IIR;
        rd_msr   = bus_rd && bus_addr == A_MSR;
        thre_arm = wr_ier && bus_wdata[1] && !ier[1] && thre;
    end

    assign unused_wbits = ^bus_wdata[DATA_W-1:MCR_W];

    // Store the enable and control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ier <= '0;
            mcr <= '0;
        end else begin
            if (wr_ier) ier <= bus_wdata[IER_W-1:0];
            if (wr_mcr) mcr <= bus_wdata[MCR_W-1:0];
        end
    end
endmodule

// File: rtl/uirq_msr.sv
// Modem status: source select (pins or loopback), sticky delta bits, status bits.
// Assumes synchronized active-low pins ordered {carrier, ring, dsr, cts}.
module uirq_msr
    import uirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NMODEM-1:0] pins_n,
    input  logic              loop_en,
    input  logic [3:0]        ctl,
    input  logic              rd_msr,
    output logic [DATA_W-1:0] msr
);
    logic [NMODEM-1:0] st, prev, delta, chg;

    // Pick the live status: the pins, or the control bits in loopback.
    always_comb begin
        if (loop_en) st = {ctl[3], ctl[2], ctl[0], ctl[1]};
        else         st = ~pins_n;
        chg = {st[3] ^ prev[3], prev[2] & ~st[2], st[1] ^ prev[1], st[0] ^ prev[0]};
    end

    // Track the previous status and accumulate the deltas until a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev  <= '0;
            delta <= '0;
        end else begin
            prev  <= st;
            delta <= (delta & ~{NMODEM{rd_msr}}) | chg;
        end
    end

    assign msr = {prev, delta};
endmodule

// File: rtl/uirq_prio.sv
// Transmit-empty flag and fixed four-level priority encoder.
// Assumes line_err and rx_ready are held by their owners until cleared.
module uirq_prio
    import uirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IER_W-1:0] ier,
    input  logic             line_err,
    input  logic             rx_ready,
    input  logic             thre,
    input  logic             thre_arm,
    input  logic             thr_wr,
    input  logic             rd_iir,
    input  logic             modem_any,
    output iid_t             id,
    output logic             pending
);
    logic thre_q, thre_pend, thre_clr;

    assign thre_clr = thr_wr || (rd_iir && id == IID_THRE);

    // Latch the transmit-empty event until it is acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thre_q    <= 1'b1;
            thre_pend <= 1'b0;
        end else begin
            thre_q    <= thre;
            thre_pend <= (thre && !thre_q) || thre_arm || (thre_pend && !thre_clr && thre);
        end
    end

    // Rank the enabled sources.
    always_comb begin
        if (ier[2] && line_err)                  id = IID_LINE;
        else if (ier[0] && rx_ready)             id = IID_RXD;
        else if (ier[1] && thre_pend && thre)    id = IID_THRE;
        else if (ier[3] && modem_any)            id = IID_MODEM;
        else                                     id = IID_NONE;
        pending = (id != IID_NONE);
    end
endmodule

// File: rtl/uart_irq_modem.sv
// Top: interrupt prioritizer and modem status/control for one serial channel.
// Assumes a synchronous bus with one-cycle strobes and asynchronous modem pins.
module uart_irq_modem
    import uirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              dlab_i,
    input  logic              line_err_i,
    input  logic              rx_ready_i,
    input  logic              thre_i,
    input  logic              cts_n_i,
    input  logic              dsr_n_i,
    input  logic              ri_n_i,
    input  logic              dcd_n_i,
    output logic [DATA_W-1:0] ier_o,
    output logic [DATA_W-1:0] iir_o,
    output logic [DATA_W-1:0] mcr_o,
    output logic [DATA_W-1:0] msr_o,
    output logic              dtr_n_o,
    output logic              rts_n_o,
    output logic              out1_n_o,
    output logic              out2_n_o,
    output logic              irq_o
);
    logic [IER_W-1:0]  ier;
    logic [MCR_W-1:0]  mcr;
    logic [NMODEM-1:0] pins_s;
    logic              thr_wr, thre_arm, rd_iir, rd_msr, pending;
    iid_t              id;

    uirq_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .dlab(dlab_i), .thre(thre_i),
        .ier(ier), .mcr(mcr), .thr_wr(thr_wr), .thre_arm(thre_arm),
        .rd_iir(rd_iir), .rd_msr(rd_msr)
    );

    uirq_sync #(.W(NMODEM), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({dcd_n_i, ri_n_i, dsr_n_i, cts_n_i}), .q(pins_s)
    );

    uirq_msr u_msr (
        .clk(clk), .rst_n(rst_n), .pins_n(pins_s), .loop_en(mcr[4]),
        .ctl(mcr[3:0]), .rd_msr(rd_msr), .msr(msr_o)
    );

    uirq_prio u_prio (
        .clk(clk), .rst_n(rst_n), .ier(ier), .line_err(line_err_i),
        .rx_ready(rx_ready_i), .thre(thre_i), .thre_arm(thre_arm),
        .thr_wr(thr_wr), .rd_iir(rd_iir), .modem_any(|msr_o[3:0]),
        .id(id), .pending(pending)
    );

    // Drive register views, control pins and the gated interrupt.
    always_comb begin
        ier_o    = {{(DATA_W-IER_W){1'b0}}, ier};
        mcr_o    = {{(DATA_W-MCR_W){1'b0}}, mcr};
        iir_o    = {4'b0000, id};
        dtr_n_o  = mcr[4] | ~mcr[0];
        rts_n_o  = mcr[4] | ~mcr[1];
        out1_n_o = mcr[4] | ~mcr[2];
        out2_n_o = mcr[4] | ~mcr[3];
        irq_o    = mcr[3] & pending;
    end
endmodule

// File: rtl/uirq_checker.sv
// Property checker for uart_irq_modem, attached by bind.
// Assumes read and write strobes are never asserted in the same cycle.
module uirq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [2:0] bus_addr,
    input logic       line_err_i,
    input logic [7:0] ier_o,
    input logic [7:0] iir_o,
    input logic [7:0] mcr_o,
    input logic [7:0] msr_o,
    input logic       dtr_n_o,
    input logic       rts_n_o,
    input logic       out1_n_o,
    input logic       out2_n_o,
    input logic       irq_o
);
    // R2: an enabled line error always wins.
    a_r2_line_first: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_o[2] && line_err_i) |-> iir_o[3:0] == 4'b0110);

    // R4: reading the identification while it shows transmit-empty acknowledges it.
    a_r4_thre_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == 3'd2 && iir_o[3:0] == 4'b0010) |=> iir_o[3:0] != 4'b0010);

    // R5: the CTS delta only rises together with a change of the CTS status.
    a_r5_delta_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msr_o[0]) |-> msr_o[4] != $past(msr_o[4]));

    // R8: loopback forces all control pins inactive.
    a_r8_loop_pins: assert property (@(posedge clk) disable iff (!rst_n)
        mcr_o[4] |-> (dtr_n_o && rts_n_o && out1_n_o && out2_n_o));

    // R9: the interrupt line follows OUT2 and the pending bit.
    a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (mcr_o[3] && !iir_o[0]));
endmodule

bind uart_irq_modem uirq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .line_err_i(line_err_i), .ier_o(ier_o), .iir_o(iir_o), .mcr_o(mcr_o), .msr_o(msr_o),
    .dtr_n_o(dtr_n_o), .rts_n_o(rts_n_o), .out1_n_o(out1_n_o), .out2_n_o(out2_n_o),
    .irq_o(irq_o)
);

// File: tb/uart_irq_modem_bench.sv
module uart_irq_modem_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, dlab_i = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       line_err_i = 1'b0, rx_ready_i = 1'b0, thre_i = 1'b0;
    logic       cts_n_i = 1'b1, dsr_n_i = 1'b1, ri_n_i = 1'b1, dcd_n_i = 1'b1;
    logic [7:0] ier_o, iir_o, mcr_o, msr_o;
    logic       dtr_n_o, rts_n_o, out1_n_o, out2_n_o, irq_o;
    int         checks = 0, errors = 0, cycles = 0;
    logic       done = 1'b0;
    logic [7:0] rv;

    always #4 clk = ~clk;

    uart_irq_modem u_uart_irq_modem (.*);

    // Fields: [13:10] IER, [9] line error, [8] rx ready, [7:0] expected IIR.
    localparam logic [13:0] VEC [10] = '{
        {4'hF, 1'b1, 1'b1, 8'h06}, {4'hF, 1'b0, 1'b1, 8'h04},
        {4'hF, 1'b0, 1'b0, 8'h02}, {4'h8, 1'b0, 1'b0, 8'h00},
        {4'h0, 1'b1, 1'b1, 8'h01}, {4'h4, 1'b0, 1'b1, 8'h01},
        {4'h1, 1'b1, 1'b1, 8'h04}, {4'h2, 1'b1, 1'b1, 8'h02},
        {4'hC, 1'b1, 1'b0, 8'h06}, {4'h9, 1'b0, 1'b0, 8'h00}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        bus_rd = 1'b1; bus_addr = a;
        v = (a == 3'd2) ? iir_o : msr_o;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] pins();
        return {4'h0, dtr_n_o, rts_n_o, out1_n_o, out2_n_o};
    endfunction

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog actual %0d expected below 100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        // R10 reset state
        chk("R10 ier", ier_o, 8'h00);
        chk("R10 mcr", mcr_o, 8'h00);
        chk("R10 msr low", {4'h0, msr_o[3:0]}, 8'h00);
        chk("R10 iir", iir_o, 8'h01);
        chk("R10 pins", pins(), 8'h0F);
        chk("R10 irq", {7'h0, irq_o}, 8'h00);

        // Setup: transmit-empty rise and a CTS change, OUT2 on.
        thre_i = 1'b1; cts_n_i = 1'b0;
        wait_n(5);
        wr(3'd4, 8'h08);
        for (int i = 0; i < 10; i++) begin
            wr(3'd1, {4'h0, VEC[i][13:10]});
            line_err_i = VEC[i][9]; rx_ready_i = VEC[i][8];
            #1;
            chk("R1 ier", ier_o, {4'h0, VEC[i][13:10]});
            chk("R2 R3 iir", iir_o, VEC[i][7:0]);
            chk("R9 irq", {7'h0, irq_o}, {7'h0, ~VEC[i][0]});
        end
        line_err_i = 1'b0; rx_ready_i = 1'b0;

        // R4 IIR read acknowledges transmit-empty.
        wr(3'd1, 8'h02);
        chk("R4 thre pending", iir_o, 8'h02);
        rd(3'd2, rv);
        chk("R4 read value", rv, 8'h02);
        chk("R4 cleared by read", iir_o, 8'h01);
        wr(3'd1, 8'h00); wr(3'd1, 8'h02);
        chk("R4 rearm by enable", iir_o, 8'h02);
        // R11 divisor access blocks IER and THR
        dlab_i = 1'b1;
        wr(3'd0, 8'h55);
        chk("R11 thr write ignored", iir_o, 8'h02);
        wr(3'd1, 8'h0F);
        chk("R11 ier write ignored", ier_o, 8'h02);
        dlab_i = 1'b0;
        wr(3'd0, 8'h55);
        chk("R4 cleared by thr write", iir_o, 8'h01);
        thre_i = 1'b0; @(negedge clk); thre_i = 1'b1; @(negedge clk);
        chk("R4 set by rise", iir_o, 8'h02);
        wr(3'd1, 8'h00);

        // R5 MSR read clears deltas
        chk("R6 cts status", msr_o, 8'h11);
        rd(3'd6, rv);
        chk("R5 msr cleared", msr_o, 8'h10);
        // R6 latency
        dsr_n_i = 1'b0;
        wait_n(2);
        chk("R6 not yet", msr_o, 8'h10);
        wait_n(1);
        chk("R6 visible", msr_o, 8'h32);
        // R5 change at the same edge as the read is kept
        dcd_n_i = 1'b0;
        wait_n(2);
        rd(3'd6, rv);
        chk("R5 coincident kept", msr_o, 8'hB8);
        rd(3'd6, rv);
        chk("R5 cleared", msr_o, 8'hB0);
        ri_n_i = 1'b0; wait_n(4);
        chk("R5 ring leading edge no delta", msr_o, 8'hF0);
        ri_n_i = 1'b1; wait_n(4);
        chk("R5 ring trailing edge", msr_o, 8'hB4);
        rd(3'd6, rv);

        // R7 control register and pins
        wr(3'd4, 8'hEF);
        chk("R7 mcr", mcr_o, 8'h0F);
        chk("R7 pins active", pins(), 8'h00);
        wr(3'd4, 8'h06);
        chk("R7 pins mixed", pins(), 8'h09);
        // R9 gate off with a modem source pending
        wr(3'd1, 8'h08);
        rd(3'd6, rv);
        wr(3'd4, 8'h00);
        wait_n(4);
        chk("R9 status before", msr_o, 8'hB0);

        // R8 loopback
        wr(3'd4, 8'h13);
        wait_n(2);
        chk("R8 loop status", msr_o, 8'h38);
        chk("R8 pins high", pins(), 8'h0F);
        chk("R9 gated off", {7'h0, irq_o}, 8'h00);
        cts_n_i = 1'b1; wait_n(4);
        chk("R8 pins ignored", msr_o, 8'h38);
        rd(3'd6, rv);
        wr(3'd4, 8'h17); wait_n(2);
        chk("R8 out1 as ring", msr_o, 8'h70);
        wr(3'd4, 8'h13); wait_n(2);
        chk("R8 ring trailing edge", msr_o, 8'h34);

        // R10 reset mid-run
        rst_n = 1'b0; wait_n(3); rst_n = 1'b1;
        chk("R10 ier after", ier_o, 8'h00);
        chk("R10 mcr after", mcr_o, 8'h00);
        chk("R10 msr deltas after", {4'h0, msr_o[3:0]}, 8'h00);
        chk("R10 pins after", pins(), 8'h0F);
        chk("R10 iir after", iir_o, 8'h01);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule